// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block belongs to the initiator side of an SPI controller and decides when the active-low target-select lines go low and return high around each transaction. It takes a transaction request with a target index, drops the matching select line, waits a programmed setup time, and then pulses a start strobe to the shift engine. When the shift engine reports that the last bit has moved, the block holds the select low for a programmed hold time. It then keeps every select high for a minimum deselect time before it accepts new work.

Four 8-bit delays in one 32-bit configuration word set this timing. All four count reference-clock cycles, not SCLK cycles. The deselect time is never shorter than one SCLK period, taken from the divider ratio. An extra quiet gap comes before a select is asserted when the request addresses a different target than the previous one and the transmit FIFO is empty. The configuration word and the divider ratio are captured when a request is accepted, so a later write affects only the next transaction.

Top module: `spi_cs_sequencer`

## Requirements
- R1: While reset is held and in the cycle after it is released, all `cs_n` bits are 1 and `busy` and `shift_start` are 0.
- R2: At most one `cs_n` bit is 0 at any time. Only bit `req_target` of the accepted request goes low, and only between the setup phase and the end of the hold phase.
- R3: `shift_start` is a one-cycle pulse. It is issued exactly `dly_cfg[7:0]` cycles after the first cycle in which the select is low.
- R4: If `xfer_done` is sampled high in cycle j, the select stays low for `dly_cfg[15:8]` further cycles and is high from cycle j+1+`dly_cfg[15:8]`. A value of 0 releases it in cycle j+1.
- R5: After the select rises, `busy` stays high with every select high for max(`dly_cfg[31:24]`, `sclk_div`, 1) cycles.
- R6: A request whose target differs from the previously accepted target, accepted while `txfifo_empty` is 1, keeps all selects high for `dly_cfg[23:16]` cycles after the acceptance cycle. Any other request, including the first one after reset, drives its select low in the cycle after acceptance.
- R7: `dly_cfg` and `sclk_div` are sampled only in the acceptance cycle. Changes during a transaction do not alter its hold or deselect times.
- R8: A request is accepted when `req_valid` is 1 and `busy` is 0. `busy` is 1 from the cycle after acceptance to the last deselect cycle. Requests presented while `busy` is 1 are ignored.
- R9: `shift_start` is only ever high in a cycle where a select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transaction request, taken when busy is low |
| req_target | input | $clog2(NUM_CS) | Index of the target to select |
| xfer_done | input | 1 | Last bit shifted, from the shift engine |
| txfifo_empty | input | 1 | Transmit FIFO holds no data |
| sclk_div | input | DIV_W | SCLK period in reference cycles |
| dly_cfg | input | 32 | Delays: [31:24] deselect, [23:16] switch gap, [15:8] hold, [7:0] setup |
| cs_n | output | NUM_CS | Active-low select lines |
| shift_start | output | 1 | One-cycle strobe telling the shift engine to begin |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions assume that the shift engine raises `xfer_done` only after it has seen `shift_start` and before the select is released, and that `req_target` is below NUM_CS. Under those two conditions the checks on single-select, strobe placement and deselect ordering follow from the block's own sequencing. The stimulus presents each request for a single cycle while `busy` is low and holds `xfer_done` for one cycle, a few cycles after the strobe. The only requests sent while `busy` is high are the ones meant to test R8, and those come during the transfer phase.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWITCH_GAP,
        ST_SETUP,
        ST_TRANSFER,
        ST_HOLD,
        ST_DESELECT
    } seq_state_e;

    // Bit order matches the configuration word: [31:24] down to [7:0]
    typedef struct packed {
        logic [FIELD_W-1:0] desel;
        logic [FIELD_W-1:0] gap;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] setup;
    } dly_cfg_t;

    function automatic logic select_phase(seq_state_e s);
        return (s == ST_SETUP) || (s == ST_TRANSFER) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/cs_seq_counter.sv
module cs_seq_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R3: an idle counter never wraps below zero
    a_r3_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

endmodule

// File: rtl/cs_seq_cfg_latch.sv
module cs_seq_cfg_latch
    import cs_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  dly_cfg_t         cfg_in,
    input  logic [DIV_W-1:0] div_in,
    output dly_cfg_t         cfg_q,
    output logic [CNT_W-1:0] desel_len
);
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] nss_w, div_w, larger;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            div_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_in;
            div_q <= div_in;
        end
    end

    always_comb begin
        nss_w  = CNT_W'(cfg_q.desel);
        div_w  = CNT_W'(div_q);
        larger = (nss_w > div_w) ? nss_w : div_w;
        desel_len = (larger == '0) ? CNT_W'(1) : larger;
    end

endmodule

// File: rtl/cs_seq_select.sv
module cs_seq_select #(
    parameter int NUM_CS = 4,
    parameter int TGT_W  = 2
) (
    input  logic              active,
    input  logic [TGT_W-1:0]  tgt,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = !(active && (tgt == TGT_W'(i)));
    end
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
    import cs_seq_pkg::*;
#(
    parameter int TGT_W = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TGT_W-1:0] req_target,
    input  logic             xfer_done,
    input  logic             txfifo_empty,
    input  dly_cfg_t         cfg_live,
    input  dly_cfg_t         cfg_q,
    input  logic [CNT_W-1:0] desel_len,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             capture,
    output logic [TGT_W-1:0] tgt_q,
    output logic             sel_active,
    output logic             shift_start,
    output logic             busy,
    output seq_state_e       state_o
);
    seq_state_e state_q, state_d;
    logic       has_prev_q;
    logic       switching;

    always_comb begin
        state_d     = state_q;
        cnt_load    = 1'b0;
        cnt_val     = '0;
        capture     = 1'b0;
        shift_start = 1'b0;
        switching   = has_prev_q && (req_target != tgt_q) && txfifo_empty
                      && (cfg_live.gap != '0);
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    capture  = 1'b1;
                    cnt_load = 1'b1;
                    if (switching) begin
                        state_d = ST_SWITCH_GAP;
                        cnt_val = CNT_W'(cfg_live.gap) - 1'b1;
                    end else begin
                        state_d = ST_SETUP;
                        cnt_val = CNT_W'(cfg_live.setup);
                    end
                end
            end
            ST_SWITCH_GAP: begin
                if (cnt_zero) begin
                    state_d  = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(cfg_q.setup);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d     = ST_TRANSFER;
                    shift_start = 1'b1;
                end
            end
            ST_TRANSFER: begin
                if (xfer_done) begin
                    cnt_load = 1'b1;
                    if (cfg_q.hold == '0) begin
                        state_d = ST_DESELECT;
                        cnt_val = desel_len - 1'b1;
                    end else begin
                        state_d = ST_HOLD;
                        cnt_val = CNT_W'(cfg_q.hold) - 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    state_d  = ST_DESELECT;
                    cnt_load = 1'b1;
                    cnt_val  = desel_len - 1'b1;
                end
            end
            ST_DESELECT: begin
                if (cnt_zero)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            tgt_q      <= '0;
            has_prev_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                tgt_q      <= req_target;
                has_prev_q <= 1'b1;
            end
        end
    end

    assign sel_active = select_phase(state_q);
    assign busy       = (state_q != ST_IDLE);
    assign state_o    = state_q;

    // R5: every sequence passes through the deselect phase before idle
    a_r5_deselect_before_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_DESELECT) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
    import cs_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [$clog2(NUM_CS)-1:0] req_target,
    input  logic                      xfer_done,
    input  logic                      txfifo_empty,
    input  logic [DIV_W-1:0]          sclk_div,
    input  logic [31:0]               dly_cfg,
    output logic [NUM_CS-1:0]         cs_n,
    output logic                      shift_start,
    output logic                      busy
);
    localparam int TGT_W = $clog2(NUM_CS);
    localparam int CNT_W = (DIV_W > FIELD_W) ? DIV_W : FIELD_W;

    dly_cfg_t         cfg_live, cfg_q;
    logic [CNT_W-1:0] desel_len, cnt_val;
    logic             cnt_load, cnt_zero, capture, sel_active;
    logic [TGT_W-1:0] tgt_q;
    seq_state_e       state;

    assign cfg_live = dly_cfg_t'(dly_cfg);

    cs_seq_cfg_latch #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .capture(capture), .cfg_in(cfg_live),
        .div_in(sclk_div), .cfg_q(cfg_q), .desel_len(desel_len)
    );

    cs_seq_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    cs_seq_ctrl #(.TGT_W(TGT_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
        .xfer_done(xfer_done), .txfifo_empty(txfifo_empty), .cfg_live(cfg_live),
        .cfg_q(cfg_q), .desel_len(desel_len), .cnt_zero(cnt_zero),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .capture(capture), .tgt_q(tgt_q),
        .sel_active(sel_active), .shift_start(shift_start), .busy(busy),
        .state_o(state)
    );

    cs_seq_select #(.NUM_CS(NUM_CS), .TGT_W(TGT_W)) u_sel (
        .active(sel_active), .tgt(tgt_q), .cs_n(cs_n)
    );

    // R2: never more than one select low
    a_r2_one_low: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R9: start strobe only while a target is selected
    a_r9_start_needs_cs: assert property (@(posedge clk) disable iff (rst)
        shift_start |-> (cs_n != '1));

    // R8: a low select implies the sequencer is busy
    a_r8_cs_implies_busy: assert property (@(posedge clk) disable iff (rst)
        (cs_n != '1) |-> busy);

    // R6: selects stay high throughout the switch gap
    a_r6_gap_selects_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SWITCH_GAP) |-> (cs_n == '1));

endmodule

// File: tb/tb_spi_cs_sequencer.sv
module tb_spi_cs_sequencer;
    localparam int NUM_CS = 4;
    localparam int DIV_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_target = '0;
    logic              xfer_done = 1'b0;
    logic              txfifo_empty = 1'b0;
    logic [DIV_W-1:0]  sclk_div = 8'd1;
    logic [31:0]       dly_cfg = '0;
    logic [NUM_CS-1:0] cs_n;
    logic              shift_start;
    logic              busy;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int last_tgt = 0;
    bit has_last = 1'b0;

    spi_cs_sequencer #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
        .xfer_done(xfer_done), .txfifo_empty(txfifo_empty), .sclk_div(sclk_div),
        .dly_cfg(dly_cfg), .cs_n(cs_n), .shift_start(shift_start), .busy(busy)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic run_txn(input int tgt, input int ini, input int aft, input int nss,
                           input int btw, input int div, input bit fe, input int xlen,
                           input bit poke);
        int n;
        int exp_gap;
        int exp_desel;
        logic [3:0] exp_cs;
        exp_gap   = (has_last && tgt != last_tgt && fe) ? btw : 0;
        exp_desel = (nss > div) ? nss : div;
        if (exp_desel < 1) exp_desel = 1;
        exp_cs = ~(4'b1 << tgt);

        @(negedge clk);
        dly_cfg      = {8'(nss), 8'(btw), 8'(aft), 8'(ini)};
        sclk_div     = 8'(div);
        txfifo_empty = fe;
        req_target   = 2'(tgt);
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);

        n = 0;
        while (cs_n == 4'hF && n < 300) begin n++; @(negedge clk); end
        check(n == exp_gap, "R6 gap length", n, exp_gap);
        check(cs_n == exp_cs, "R2 select line", int'(cs_n), int'(exp_cs));

        n = 0;
        while (!shift_start && n < 300) begin n++; @(negedge clk); end
        check(n == ini, "R3 setup length", n, ini);
        check(cs_n == exp_cs, "R9 start with select low", int'(cs_n), int'(exp_cs));

        if (poke) begin
            dly_cfg    = ~dly_cfg;
            sclk_div   = 8'd200;
            req_target = 2'(tgt + 1);
            req_valid  = 1'b1;
        end
        @(negedge clk);
        check(shift_start == 1'b0, "R3 strobe single cycle", int'(shift_start), 0);
        repeat (xlen) @(negedge clk);
        check(cs_n == exp_cs, "R2 held during transfer", int'(cs_n), int'(exp_cs));
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;

        n = 0;
        while (cs_n != 4'hF && n < 300) begin n++; @(negedge clk); end
        check(n == aft, poke ? "R7 hold with changed config" : "R4 hold length", n, aft);

        n = 0;
        while (busy && n < 600) begin
            if (cs_n != 4'hF) check(1'b0, "R5 selects high in deselect", int'(cs_n), 15);
            n++;
            @(negedge clk);
        end
        check(n == exp_desel, poke ? "R7 deselect with changed config" : "R5 deselect length",
              n, exp_desel);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            check(busy == 1'b0 && cs_n == 4'hF, "R8 ignored request",
                  int'({busy, cs_n}), 15);
        end
        last_tgt = tgt;
        has_last = 1'b1;
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        check(cs_n == 4'hF && !busy && !shift_start, "R1 reset state",
              int'({busy, shift_start, cs_n}), 15);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 4'hF && !busy && !shift_start, "R1 after release",
              int'({busy, shift_start, cs_n}), 15);

        k = 0;
        for (int ini = 0; ini < 4; ini++)
            for (int aft = 0; aft < 4; aft++)
                for (int nss = 0; nss < 4; nss++)
                    for (int dv = 0; dv < 2; dv++) begin
                        run_txn((k / 2) % 4, ini, aft, nss, k % 3, dv ? 3 : 1,
                                (k % 3) != 0, k % 3, (k % 5) == 0);
                        k++;
                    end

        run_txn(0, 2, 1, 0, 5, 6, 1'b1, 1, 1'b0);
        run_txn(3, 0, 0, 9, 4, 2, 1'b1, 0, 1'b0);
        run_txn(1, 1, 2, 1, 7, 1, 1'b0, 2, 1'b0);
        run_txn(1, 0, 0, 0, 7, 0, 1'b1, 0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule